// File: doc/BRIEF.md
# Dynamic Voltage Scaling Reference Ramp

This block produces the digital reference code that drives the output-voltage DAC of a step-down converter. Two 5-bit setpoint codes, V1 and V2, are presented on its inputs. A select bit picks which of them is the target. The current reference code walks toward that target one code at a time. Each code is held for a programmable dwell before the next move, so the slope of the reference is limited whether the voltage rises or falls.

The code maps to millivolts on a 50 mV grid starting at 800 mV. The two lowest codes share the 800 mV level. A move between those two codes is therefore taken at once, with no dwell. While the enable is low, the reference sits at the lowest code. When the enable rises, the reference climbs from the lowest code toward the target, and this climb serves as the soft start. The dwell is counted in clock cycles, derived from a clock-frequency parameter. A fast rate gives about 2.67 µs per code and a slow rate about 10.67 µs per code.

Top module: `dvs_ramp_top`

## Requirements
- R1: The millivolt output is 800 for codes 0 and 1 and rises by 50 per code above 1, reaching 2300 at code 31.
- R2: With selV1 = 1 the target is v1Code; with selV1 = 0 the target is v2Code.
- R3: While enable is low, busy is 0 at once and refCode is 0 from the next clock edge on, whatever the setpoints are.
- R4: When the target level is above the current level, refCode rises by one level per dwell period. The first rise lands dwell cycles after the ramp starts.
- R5: The dwell is 534 cycles at 200 MHz when slowRate = 0 and 2134 cycles when slowRate = 1. Both are derived from the clock-frequency parameter, for 2.67 µs and 10.67 µs.
- R6: When the target level is below the current level, refCode falls by one level per dwell period, at the same rate as a rise.
- R7: A move between codes 0 and 1 completes at the next clock edge with no dwell, and busy stays 0 throughout.
- R8: A change of target in the middle of a ramp restarts the dwell count from the current code. The next move then lands a full dwell after the change.
- R9: While enable is high, busy is 1 exactly when the current level differs from the target level.
- R10: A rising enable starts a ramp from code 0 up to the target, one level per dwell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed-rate clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Converter enable; rising edge starts the soft start |
| v1Code | input | 5 | First setpoint code |
| v2Code | input | 5 | Second setpoint code |
| selV1 | input | 1 | 1 selects v1Code as target, 0 selects v2Code |
| slowRate | input | 1 | 0 selects the short dwell, 1 the long dwell |
| refCode | output | 5 | Current reference code to the DAC |
| refMv | output | 12 | Millivolt equivalent of refCode |
| busy | output | 1 | Current level differs from target level |

## Verification
Busy is combinational on the inputs, so it is due in the first sampled cycle after a stimulus. A snap between codes 0 and 1 appears one cycle later. The k-th ramp move appears k times the dwell plus one cycles after the stimulus. The driver records the cycle index at which it applied each stimulus and queues the expected code and busy for the exact cycles on either side of every due move. The monitor compares them at the falling edge of that cycle. A move that comes a cycle early or late, or a dwell that failed to restart, therefore shows up as a mismatch.

// File: rtl/dvs_ramp_pkg.sv
package dvs_ramp_pkg;

  // Strobes from the control to the datapath; at most one is active.
  typedef struct packed {
    logic clear;   // force the lowest code
    logic snap;    // load target code directly (same level)
    logic inc;     // move one level up
    logic dec;     // move one level down
  } rampCmd_t;

  // Level comparison reported by the datapath.
  typedef struct packed {
    logic tgtAbove;
    logic tgtBelow;
    logic sameLevelDiffCode;
  } levelCmp_t;

endpackage

// File: rtl/dvs_ramp_datapath.sv
module dvs_ramp_datapath
  import dvs_ramp_pkg::*;
#(
  parameter int CODE_W   = 5,
  parameter int MV_W     = 12,
  parameter int FLOOR_MV = 800,
  parameter int STEP_MV  = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] v1Code,
  input  logic [CODE_W-1:0] v2Code,
  input  logic              selV1,
  input  rampCmd_t          cmd,
  output logic [CODE_W-1:0] curCode,
  output logic [CODE_W-1:0] tgtCode,
  output levelCmp_t         cmp,
  output logic [MV_W-1:0]   mvOut
);

  localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

  // Codes 0 and 1 share the lowest level.
  function automatic logic [CODE_W-1:0] levelOf(input logic [CODE_W-1:0] c);
    return (c == '0) ? ONE : c;
  endfunction

  logic [CODE_W-1:0] curLvl;
  logic [CODE_W-1:0] tgtLvl;

  assign tgtCode = selV1 ? v1Code : v2Code;
  assign curLvl  = levelOf(curCode);
  assign tgtLvl  = levelOf(tgtCode);

  assign cmp.tgtAbove          = tgtLvl > curLvl;
  assign cmp.tgtBelow          = tgtLvl < curLvl;
  assign cmp.sameLevelDiffCode = (tgtLvl == curLvl) && (tgtCode != curCode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          curCode <= '0;
    else if (cmd.clear) curCode <= '0;
    else if (cmd.snap)  curCode <= tgtCode;
    else if (cmd.inc)   curCode <= curLvl + ONE;
    else if (cmd.dec)   curCode <= curLvl - ONE;
  end

  assign mvOut = MV_W'(FLOOR_MV + STEP_MV * (int'(curLvl) - 1));

  // R4 / R6: the level never moves by more than one step per edge
  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.clear |=> (curLvl == $past(curLvl)) || (curLvl == $past(curLvl) + ONE)
                   || (curLvl + ONE == $past(curLvl)));

  // R7: a snap never changes the voltage level
  assert_snap_level_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmd.snap |=> curLvl == $past(curLvl));

  // R3: disabled means lowest code on the following edge
  assert_idle_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clear |=> curCode == '0);

endmodule

// File: rtl/dvs_ramp_ctrl.sv
module dvs_ramp_ctrl
  import dvs_ramp_pkg::*;
#(
  parameter int CODE_W   = 5,
  parameter int FAST_CYC = 534,
  parameter int SLOW_CYC = 2134
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              slowRate,
  input  logic [CODE_W-1:0] tgtCode,
  input  levelCmp_t         cmp,
  output rampCmd_t          cmd,
  output logic              busy
);

  localparam int MAX_CYC = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic              enQ;
  logic [CODE_W-1:0] tgtQ;
  logic [CNT_W-1:0]  dwellCnt;
  logic [CNT_W-1:0]  cntBase;
  logic [CNT_W-1:0]  limit;
  logic              restart;
  logic              moving;
  logic              stepNow;

  assign restart = !enQ || (tgtCode != tgtQ);
  assign cntBase = restart ? '0 : dwellCnt;
  assign limit   = slowRate ? CNT_W'(SLOW_CYC - 1) : CNT_W'(FAST_CYC - 1);
  assign moving  = enable && (cmp.tgtAbove || cmp.tgtBelow);
  assign stepNow = moving && (cntBase >= limit);

  assign cmd.clear = !enable;
  assign cmd.snap  = enable && cmp.sameLevelDiffCode;
  assign cmd.inc   = stepNow && cmp.tgtAbove;
  assign cmd.dec   = stepNow && cmp.tgtBelow;
  assign busy      = moving;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ      <= 1'b0;
      tgtQ     <= '0;
      dwellCnt <= '0;
    end else begin
      enQ      <= enable;
      tgtQ     <= tgtCode;
      dwellCnt <= (!moving || stepNow) ? '0 : cntBase + CNT_W'(1);
    end
  end

  // R9: at most one datapath strobe at a time
  assert_cmd_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmd));

  // R5: two moves are never on adjacent edges (dwell is longer than one cycle)
  assert_dwell_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.inc || cmd.dec) |=> !(cmd.inc || cmd.dec));

  // R8: a target change mid-ramp postpones the next move
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    (enable && enQ && (tgtCode != tgtQ)) |=> !(cmd.inc || cmd.dec));

endmodule

// File: rtl/dvs_ramp_top.sv
module dvs_ramp_top
  import dvs_ramp_pkg::*;
#(
  parameter int CODE_W       = 5,
  parameter int MV_W         = 12,
  parameter int CLK_FREQ_MHZ = 200,
  parameter int FAST_STEP_NS = 2670,
  parameter int SLOW_STEP_NS = 10670,
  parameter int FLOOR_MV     = 800,
  parameter int STEP_MV      = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [CODE_W-1:0] v1Code,
  input  logic [CODE_W-1:0] v2Code,
  input  logic              selV1,
  input  logic              slowRate,
  output logic [CODE_W-1:0] refCode,
  output logic [MV_W-1:0]   refMv,
  output logic              busy
);

  localparam int FAST_CYC = CLK_FREQ_MHZ * FAST_STEP_NS / 1000;
  localparam int SLOW_CYC = CLK_FREQ_MHZ * SLOW_STEP_NS / 1000;

  rampCmd_t          cmd;
  levelCmp_t         cmp;
  logic [CODE_W-1:0] tgtCode;

  dvs_ramp_ctrl #(
    .CODE_W  (CODE_W),
    .FAST_CYC(FAST_CYC),
    .SLOW_CYC(SLOW_CYC)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .slowRate(slowRate),
    .tgtCode (tgtCode),
    .cmp     (cmp),
    .cmd     (cmd),
    .busy    (busy)
  );

  dvs_ramp_datapath #(
    .CODE_W  (CODE_W),
    .MV_W    (MV_W),
    .FLOOR_MV(FLOOR_MV),
    .STEP_MV (STEP_MV)
  ) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .v1Code (v1Code),
    .v2Code (v2Code),
    .selV1  (selV1),
    .cmd    (cmd),
    .curCode(refCode),
    .tgtCode(tgtCode),
    .cmp    (cmp),
    .mvOut  (refMv)
  );

endmodule

// File: tb/tb_dvs_ramp_top.sv
`timescale 1ns/1ps
module tb_dvs_ramp_top;

  localparam int PF = 534;    // R5 fast dwell at 200 MHz
  localparam int PS = 2134;   // R5 slow dwell at 200 MHz

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [4:0] v1Code = '0;
  logic [4:0] v2Code = '0;
  logic       selV1 = 1'b1;
  logic       slowRate = 1'b0;
  logic [4:0] refCode;
  logic [11:0] refMv;
  logic       busy;

  always #2.5 clk = ~clk;

  dvs_ramp_top dut (
    .clk(clk), .rstN(rstN), .enable(enable), .v1Code(v1Code), .v2Code(v2Code),
    .selV1(selV1), .slowRate(slowRate), .refCode(refCode), .refMv(refMv), .busy(busy)
  );

  typedef struct {
    int    cyc;
    int    code;
    int    bsy;
    string req;
  } item_t;

  item_t expQ[$];
  int cyc = 0;
  int checks = 0;
  int failures = 0;
  int dAt = 0;
  bit done = 0;

  function automatic int expMv(input int c);
    return (c <= 1) ? 800 : 800 + 50 * (c - 1);
  endfunction

  task automatic pushExp(input int at, input int code, input int bsy, input string req);
    item_t it;
    it.cyc = at; it.code = code; it.bsy = bsy; it.req = req;
    expQ.push_back(it);
  endtask

  // Monitor: pops expected items at their due cycle
  always @(negedge clk) begin
    cyc = cyc + 1;
    while (expQ.size() > 0 && expQ[0].cyc <= cyc) begin
      item_t it;
      it = expQ.pop_front();
      checks++;
      if (it.cyc != cyc || int'(refCode) != it.code || int'(refMv) != expMv(it.code)
          || int'(busy) != it.bsy) begin
        failures++;
        $display("FAIL %s cyc=%0d/%0d code=%0d exp=%0d mv=%0d exp=%0d busy=%0d exp=%0d",
                 it.req, cyc, it.cyc, refCode, it.code, refMv, expMv(it.code), busy, it.bsy);
      end
    end
  end

  task automatic startDrive();
    @(posedge clk);
    #1;
  endtask

  task automatic waitUntil(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    dAt = cyc;
    pushExp(dAt + 1, 0, 0, "R3 reset");
    pushExp(dAt + 2, 0, 0, "R1 floor");
    waitUntil(dAt + 4);

    // R3: disabled, setpoint ignored
    startDrive(); v1Code = 5'd10; dAt = cyc;
    pushExp(dAt + 1, 0, 0, "R3");
    pushExp(dAt + 5, 0, 0, "R3");
    waitUntil(dAt + 6);

    // R10 / R4: soft start to code 3, fast dwell
    startDrive(); v1Code = 5'd3; enable = 1'b1; dAt = cyc;
    pushExp(dAt + 1, 0, 1, "R10");
    pushExp(dAt + PF, 0, 1, "R4");
    pushExp(dAt + 1 + PF, 2, 1, "R4");
    pushExp(dAt + 2 * PF, 2, 1, "R4");
    pushExp(dAt + 1 + 2 * PF, 3, 0, "R9");
    waitUntil(dAt + 2 * PF + 4);

    // R2 / R5 / R6: select V2 = 1, slow fall
    startDrive(); slowRate = 1'b1; v2Code = 5'd1; selV1 = 1'b0; dAt = cyc;
    pushExp(dAt + 1, 3, 1, "R2");
    pushExp(dAt + PS, 3, 1, "R5");
    pushExp(dAt + 1 + PS, 2, 1, "R6");
    pushExp(dAt + 2 * PS, 2, 1, "R6");
    pushExp(dAt + 1 + 2 * PS, 1, 0, "R6");
    waitUntil(dAt + 2 * PS + 4);

    // R7: snap 1 -> 0 and back
    startDrive(); v2Code = 5'd0; dAt = cyc;
    pushExp(dAt + 1, 1, 0, "R7");
    pushExp(dAt + 2, 0, 0, "R7");
    waitUntil(dAt + 4);
    startDrive(); v2Code = 5'd1; dAt = cyc;
    pushExp(dAt + 1, 0, 0, "R7");
    pushExp(dAt + 2, 1, 0, "R7");
    waitUntil(dAt + 4);

    // R8: restart mid ramp
    startDrive(); slowRate = 1'b0; v2Code = 5'd6; dAt = cyc;
    pushExp(dAt + 1 + PF, 2, 1, "R4");
    waitUntil(dAt + PF + 200);
    startDrive(); v2Code = 5'd4; dAt = cyc;
    pushExp(dAt + 1, 2, 1, "R8");
    pushExp(dAt + PF, 2, 1, "R8");
    pushExp(dAt + 1 + PF, 3, 1, "R8");
    pushExp(dAt + 1 + 2 * PF, 4, 0, "R8");
    waitUntil(dAt + 2 * PF + 4);

    // R2: switch target back to V1
    startDrive(); v1Code = 5'd8; selV1 = 1'b1; dAt = cyc;
    pushExp(dAt + 1, 4, 1, "R2");
    pushExp(dAt + 1 + PF, 5, 1, "R2");
    waitUntil(dAt + PF + 4);

    // R3: disable mid ramp
    startDrive(); enable = 1'b0; dAt = cyc;
    pushExp(dAt + 1, 5, 0, "R3");
    pushExp(dAt + 2, 0, 0, "R3");
    waitUntil(dAt + 4);

    // R1 / R10: full-scale soft start to 31
    startDrive(); v1Code = 5'd31; enable = 1'b1; dAt = cyc;
    pushExp(dAt + 1 + 10 * PF, 11, 1, "R1");
    pushExp(dAt + 30 * PF, 30, 1, "R10");
    pushExp(dAt + 1 + 30 * PF, 31, 0, "R1");
    waitUntil(dAt + 30 * PF + 4);

    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R9 pending=%0d exp=0", expQ.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog cyc=%0d exp=finish", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule